// File: doc/BRIEF.md
# Dual-Port Byte Memory with Shared Address/Data Buses

This block is a 256-byte memory reached through two independent ports, A and B. The whole model is synchronous to one system clock. Each port has one 8-bit bus that carries first an address and then data. Three active-low strobes control the port: select, read strobe and write strobe. All controls are sampled on the rising clock edge, and each port's sequencer detects edges by comparing the sampled controls with its own state. A real pad would be tri-state. Here each port instead has a bus input, a bus output and a drive-enable, and a pad wrapper outside the block combines them.

A transaction on one port runs in a fixed order. The port is first selected, which latches the address from the bus. It then either reads, driving the addressed byte while the read strobe is low, or writes, taking the bus value as data and storing it when the select or the write strobe rises. The two ports run fully in parallel. Same-cycle writes to one address are resolved in favour of port A, and both ports raise a one-cycle collision flag.

Top module: `dual_port_mux_ram`

## Requirements
- R1: Every one of the 256 addresses holds an 8-bit byte written through either port and read back through either port. This includes the lowest address 0x00 and the highest address 0xFF.
- R2: The address is captured from the bus in the first clock cycle in which the port's select is sampled low after being high (or after reset). Later bus values leave the captured address unchanged until select is sampled high again.
- R3: In any cycle after the capture cycle in which select and read strobe are low and write strobe is high, the drive-enable is 1 and the bus output carries the stored byte at the captured address. Whenever the drive-enable is 0, the bus output is 0x00.
- R4: In any cycle in which select or read strobe is sampled high, the drive-enable is 0. A new read may start again later under the same select.
- R5: A write phase begins after the capture cycle when write strobe is low, read strobe is high and select is low. The write is stored in the first cycle in which select or write strobe is sampled high, using the bus value of that cycle. The new byte is visible to reads from the next cycle onward.
- R6: While read strobe and write strobe are both low, the port neither drives nor writes. If the read strobe falls during a write phase, that write is abandoned and the location keeps its old byte.
- R7: Both ports may read at the same time, including the same address, and each receives the stored byte.
- R8: While one port reads an address that the other port writes, the reader sees the complete old byte up to and including the store cycle, and the complete new byte from the next cycle.
- R9: When both ports store to the same address in the same cycle, the byte from port A is kept.
- R10: Each port's collision flag is 1 for exactly the one cycle after a same-cycle, same-address store by both ports, and stays 0 for same-cycle stores to different addresses.
- R11: A synchronous active-low reset forces both drive-enables to 0, both bus outputs to 0x00 and both collision flags to 0. It also returns both sequencers to idle, so a read in progress stops driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_en_n | input | 1 | Port A select, active low |
| a_oe_n | input | 1 | Port A read strobe, active low |
| a_we_n | input | 1 | Port A write strobe, active low |
| a_bus_in | input | 8 | Port A shared bus, value seen at the pad |
| a_bus_out | output | 8 | Port A read data toward the pad |
| a_bus_drv | output | 1 | Port A pad drive-enable |
| a_clash | output | 1 | Port A same-address store collision pulse |
| b_en_n | input | 1 | Port B select, active low |
| b_oe_n | input | 1 | Port B read strobe, active low |
| b_we_n | input | 1 | Port B write strobe, active low |
| b_bus_in | input | 8 | Port B shared bus, value seen at the pad |
| b_bus_out | output | 8 | Port B read data toward the pad |
| b_bus_drv | output | 1 | Port B pad drive-enable |
| b_clash | output | 1 | Port B same-address store collision pulse |

## Verification
A read on one port and a store from the other port to the same address can fall in the same cycle. The bench provokes this by holding port A in a read while port B ends a write by raising its select. It expects the old byte in that store cycle and the new byte in the following cycle. Two stores can also coincide: both ports release their write strobes together on one address. The bench judges this by the collision pulse on the next cycle and by reading the address back to find port A's byte.

// File: rtl/dpmr_pkg.sv
// Package: shared types for the dual-port shared-bus memory.
// Assumes: exactly two ports, index 0 is port A (store priority), 1 is port B.
package dpmr_pkg;

    localparam int NUM_PORTS = 2;
    localparam int PORT_A    = 0;
    localparam int PORT_B    = 1;

    // Per-port sequencer phase
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // select high, nothing latched in use
        PH_OPEN  = 2'd1,   // address latched, no write phase
        PH_WRITE = 2'd2    // write strobe low with read strobe high
    } port_phase_t;

endpackage

// File: rtl/dpmr_port_seq.sv
// Module: dpmr_port_seq
// Sequences one port of the shared-bus memory. It latches the address when
// select is first sampled low, drives stored data during a read, and issues
// a one-cycle store request when a write phase ends on a select or
// write-strobe rise.
// Assumes: controls are synchronous to clk; rdata_i is an asynchronous read
// of the location at addr_o.
module dpmr_port_seq
    import dpmr_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic [BUS_W-1:0] bus_in,
    input  logic [BUS_W-1:0] rdata_i,
    output logic [BUS_W-1:0] addr_o,
    output logic             store_o,
    output logic [BUS_W-1:0] store_data_o,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_drv
);

    port_phase_t      phase_q, phase_d;
    logic [BUS_W-1:0] addr_q;
    logic             capture;

    // Detect the select fall: idle phase with select sampled low
    always_comb capture = (phase_q == PH_IDLE) && !en_n;

    // Next-phase decision from the sampled strobes
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (!en_n) phase_d = PH_OPEN;
            end
            PH_OPEN: begin
                if (en_n)                 phase_d = PH_IDLE;
                else if (!we_n && oe_n)   phase_d = PH_WRITE;
            end
            PH_WRITE: begin
                if (en_n)                 phase_d = PH_IDLE;
                else if (we_n || !oe_n)   phase_d = PH_OPEN;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Address latch, loaded only on the select fall
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (capture) addr_q <= bus_in;
    end

    // Store request: the write phase ends on a rise with read strobe high
    always_comb store_o = (phase_q == PH_WRITE) && oe_n && (en_n || we_n);

    // Store data is the bus value in the ending cycle
    always_comb store_data_o = bus_in;

    // Read drive: selected, read strobe low, write strobe high
    always_comb bus_drv = (phase_q != PH_IDLE) && !en_n && !oe_n && we_n;

    // Pad output held at zero when not driving
    always_comb bus_out = bus_drv ? rdata_i : '0;

    // Address latch visible to the storage array
    always_comb addr_o = addr_q;

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> (phase_q == PH_IDLE) || $stable(addr_q)); // R2

    AST_READ_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(en_n) || $rose(oe_n)) |-> !bus_drv); // R4

    AST_STORE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        store_o |-> ($past(!we_n) && $past(!en_n))); // R5

    AST_NO_DRIVE_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        store_o |-> !bus_drv); // R6

endmodule

// File: rtl/dpmr_mem_core.sv
// Module: dpmr_mem_core
// Storage array with one asynchronous read per port and one write per port.
// When both ports write one location in the same cycle, the lower port index
// (port A) wins.
// Assumes: no reset of the contents; reads return the stored byte before any
// write of the current cycle.
module dpmr_mem_core
    import dpmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PORTS-1:0]              wr_en,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  wr_addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]  wr_data,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  rd_addr,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]  rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Writes from the highest index down, so port A lands last and wins
    always_ff @(posedge clk) begin
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (wr_en[p]) mem[wr_addr[p]] <= wr_data[p];
        end
    end

    // One asynchronous read per port
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rd
        always_comb rd_data[g] = mem[rd_addr[g]];
    end

    AST_A_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[PORT_A] && wr_en[PORT_B] && (wr_addr[PORT_A] == wr_addr[PORT_B]))
        |=> (mem[$past(wr_addr[PORT_A])] == $past(wr_data[PORT_A]))); // R9

endmodule

// File: rtl/dpmr_clash_det.sv
// Module: dpmr_clash_det
// Flags a same-cycle store by both ports to one address, registered, so the
// flag is high in the cycle after the collision.
// Assumes: store requests last one cycle each.
module dpmr_clash_det
    import dpmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PORTS-1:0]             store,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr,
    output logic                             clash_o
);

    logic hit;

    // Same-cycle, same-address store by both ports
    always_comb hit = store[PORT_A] && store[PORT_B] && (addr[PORT_A] == addr[PORT_B]);

    // One-cycle registered pulse
    always_ff @(posedge clk) begin
        if (!rst_n) clash_o <= 1'b0;
        else        clash_o <= hit;
    end

    AST_CLASH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        clash_o |=> !clash_o); // R10

    AST_CLASH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        clash_o |-> ($past(store[PORT_A]) && $past(store[PORT_B]))); // R10

endmodule

// File: rtl/dual_port_mux_ram.sv
// Module: dual_port_mux_ram
// Top level: two port sequencers over one shared storage array, with
// same-address store collision detection. Pads are split into in/out/enable.
// Assumes: all controls synchronous to clk; the bus carries a full address.
module dual_port_mux_ram
    import dpmr_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_en_n,
    input  logic             a_oe_n,
    input  logic             a_we_n,
    input  logic [BUS_W-1:0] a_bus_in,
    output logic [BUS_W-1:0] a_bus_out,
    output logic             a_bus_drv,
    output logic             a_clash,
    input  logic             b_en_n,
    input  logic             b_oe_n,
    input  logic             b_we_n,
    input  logic [BUS_W-1:0] b_bus_in,
    output logic [BUS_W-1:0] b_bus_out,
    output logic             b_bus_drv,
    output logic             b_clash
);

    localparam int ADDR_W = BUS_W;
    localparam int DATA_W = BUS_W;

    logic [NUM_PORTS-1:0]             en_n, oe_n, we_n, store, drv;
    logic [NUM_PORTS-1:0][BUS_W-1:0]  bus_in, bus_out, addr, sdata, rdata;
    logic                             clash;

    // Gather per-port pins into indexed vectors
    always_comb begin
        en_n   = {b_en_n,   a_en_n};
        oe_n   = {b_oe_n,   a_oe_n};
        we_n   = {b_we_n,   a_we_n};
        bus_in = {b_bus_in, a_bus_in};
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        dpmr_port_seq #(.BUS_W(BUS_W)) u_seq (
            .clk          (clk),
            .rst_n        (rst_n),
            .en_n         (en_n[g]),
            .oe_n         (oe_n[g]),
            .we_n         (we_n[g]),
            .bus_in       (bus_in[g]),
            .rdata_i      (rdata[g]),
            .addr_o       (addr[g]),
            .store_o      (store[g]),
            .store_data_o (sdata[g]),
            .bus_out      (bus_out[g]),
            .bus_drv      (drv[g])
        );
    end

    dpmr_mem_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store),
        .wr_addr (addr),
        .wr_data (sdata),
        .rd_addr (addr),
        .rd_data (rdata)
    );

    dpmr_clash_det #(.ADDR_W(ADDR_W)) u_clash (
        .clk     (clk),
        .rst_n   (rst_n),
        .store   (store),
        .addr    (addr),
        .clash_o (clash)
    );

    // Scatter results back to the named pins
    always_comb begin
        a_bus_out = bus_out[PORT_A];
        b_bus_out = bus_out[PORT_B];
        a_bus_drv = drv[PORT_A];
        b_bus_drv = drv[PORT_B];
        a_clash   = clash;
        b_clash   = clash;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (!a_clash && !b_clash)); // R11

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_bus_drv |-> (a_bus_out == '0)) and (!b_bus_drv |-> (b_bus_out == '0))); // R3

endmodule

// File: tb/dual_port_mux_ram_tb.sv
module dual_port_mux_ram_tb;

    // Control nibble order {en_n, oe_n, we_n}
    localparam logic [2:0] I  = 3'b111; // idle
    localparam logic [2:0] S  = 3'b011; // selected only
    localparam logic [2:0] RD = 3'b001; // read
    localparam logic [2:0] WR = 3'b010; // write
    localparam logic [2:0] BL = 3'b000; // both strobes low
    localparam logic [2:0] EW = 3'b110; // select high, write strobe low

    typedef struct packed {
        logic [2:0] a_ctl;
        logic [7:0] a_bus;
        logic [2:0] b_ctl;
        logic [7:0] b_bus;
        logic       a_drv;
        logic [7:0] a_exp;
        logic       b_drv;
        logic [7:0] b_exp;
        logic       clash;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 44;
    localparam vec_t VECS [NV] = '{
        // R5: port A writes 0x5A to 0x10
        '{S,  8'h10, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd5},
        '{WR, 8'h5A, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd5},
        '{WR, 8'h77, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd5},
        '{S,  8'h5A, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd5},
        '{I,  8'h00, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd5},
        // R2/R3/R4: read 0x10, bus changes after capture
        '{S,  8'h10, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd2},
        '{RD, 8'h33, I, 8'h00, 1'b1, 8'h5A, 1'b0, 8'h00, 1'b0, 4'd2},
        '{RD, 8'h33, I, 8'h00, 1'b1, 8'h5A, 1'b0, 8'h00, 1'b0, 4'd3},
        '{S,  8'h33, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd4},
        '{RD, 8'h33, I, 8'h00, 1'b1, 8'h5A, 1'b0, 8'h00, 1'b0, 4'd4},
        '{3'b101, 8'h00, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd4},
        // R7: both ports read 0x10
        '{S,  8'h10, S, 8'h10, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd7},
        '{RD, 8'h00, RD, 8'h00, 1'b1, 8'h5A, 1'b1, 8'h5A, 1'b0, 4'd7},
        '{I,  8'h00, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd7},
        // R8: A reads 0x10 while B stores 0xC3 there
        '{S,  8'h10, S, 8'h10, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd8},
        '{RD, 8'h00, WR, 8'hC3, 1'b1, 8'h5A, 1'b0, 8'h00, 1'b0, 4'd8},
        '{RD, 8'h00, WR, 8'hC3, 1'b1, 8'h5A, 1'b0, 8'h00, 1'b0, 4'd8},
        '{RD, 8'h00, EW, 8'hC3, 1'b1, 8'h5A, 1'b0, 8'h00, 1'b0, 4'd8},
        '{RD, 8'h00, I, 8'h00, 1'b1, 8'hC3, 1'b0, 8'h00, 1'b0, 4'd8},
        '{I,  8'h00, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd8},
        // R9/R10: both store to 0x40
        '{S,  8'h40, S, 8'h40, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd10},
        '{WR, 8'hAA, WR, 8'hBB, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd10},
        '{S,  8'hAA, S, 8'hBB, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd10},
        '{I,  8'h00, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'd10},
        '{I,  8'h00, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd10},
        '{I,  8'h00, S, 8'h40, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd9},
        '{I,  8'h00, RD, 8'h00, 1'b0, 8'h00, 1'b1, 8'hAA, 1'b0, 4'd9},
        '{I,  8'h00, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd9},
        // R10: stores to different addresses, no collision
        '{S,  8'h41, S, 8'h42, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd10},
        '{WR, 8'h01, WR, 8'h02, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd10},
        '{EW, 8'h01, EW, 8'h02, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd10},
        '{I,  8'h00, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd10},
        '{S,  8'h42, S, 8'h41, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd5},
        '{RD, 8'h00, RD, 8'h00, 1'b1, 8'h02, 1'b1, 8'h01, 1'b0, 4'd5},
        '{I,  8'h00, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd5},
        // R6: both strobes low, then an abandoned write
        '{S,  8'h10, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd6},
        '{BL, 8'hEE, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd6},
        '{RD, 8'hEE, I, 8'h00, 1'b1, 8'hC3, 1'b0, 8'h00, 1'b0, 4'd6},
        '{WR, 8'hEE, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd6},
        '{BL, 8'hEE, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd6},
        '{I,  8'hEE, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd6},
        '{S,  8'h10, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd6},
        '{RD, 8'h00, I, 8'h00, 1'b1, 8'hC3, 1'b0, 8'h00, 1'b0, 4'd6},
        '{I,  8'h00, I, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd6}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_en_n = 1'b1, a_oe_n = 1'b1, a_we_n = 1'b1;
    logic       b_en_n = 1'b1, b_oe_n = 1'b1, b_we_n = 1'b1;
    logic [7:0] a_bus_in = '0, b_bus_in = '0;
    logic [7:0] a_bus_out, b_bus_out;
    logic       a_bus_drv, b_bus_drv, a_clash, b_clash;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    dual_port_mux_ram u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_en_n    (a_en_n),
        .a_oe_n    (a_oe_n),
        .a_we_n    (a_we_n),
        .a_bus_in  (a_bus_in),
        .a_bus_out (a_bus_out),
        .a_bus_drv (a_bus_drv),
        .a_clash   (a_clash),
        .b_en_n    (b_en_n),
        .b_oe_n    (b_oe_n),
        .b_we_n    (b_we_n),
        .b_bus_in  (b_bus_in),
        .b_bus_out (b_bus_out),
        .b_bus_drv (b_bus_drv),
        .b_clash   (b_clash)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_a(input logic [2:0] ctl, input logic [7:0] bus);
        {a_en_n, a_oe_n, a_we_n} = ctl;
        a_bus_in = bus;
    endtask

    task automatic set_b(input logic [2:0] ctl, input logic [7:0] bus);
        {b_en_n, b_oe_n, b_we_n} = ctl;
        b_bus_in = bus;
    endtask

    // R1: store through port B and read back through port A
    task automatic b_store_a_read(input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk); set_b(S, addr);
        @(negedge clk); set_b(WR, data);
        @(negedge clk); set_b(S, data);
        @(negedge clk); set_b(I, 8'h00);
        @(negedge clk); set_a(S, addr);
        @(negedge clk); set_a(RD, 8'h00);
        #5;
        check(a_bus_drv && (a_bus_out == data), "R1 readback",
              {23'd0, a_bus_drv, a_bus_out}, {23'd0, 1'b1, data});
        @(negedge clk); set_a(I, 8'h00);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        #5;
        // R11: reset state
        check(!a_bus_drv && !b_bus_drv && a_bus_out == 0 && b_bus_out == 0
              && !a_clash && !b_clash, "R11 reset outputs",
              {a_bus_drv, b_bus_drv, a_clash, b_clash, a_bus_out, b_bus_out}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_a(VECS[i].a_ctl, VECS[i].a_bus);
            set_b(VECS[i].b_ctl, VECS[i].b_bus);
            #5;
            check((a_bus_drv == VECS[i].a_drv) && (a_bus_out == VECS[i].a_exp)
                  && (b_bus_drv == VECS[i].b_drv) && (b_bus_out == VECS[i].b_exp)
                  && (a_clash == VECS[i].clash) && (b_clash == VECS[i].clash),
                  $sformatf("R%0d row %0d", VECS[i].req, i),
                  {5'd0, a_clash, b_clash, a_bus_drv, a_bus_out, b_bus_drv, b_bus_out},
                  {5'd0, VECS[i].clash, VECS[i].clash, VECS[i].a_drv, VECS[i].a_exp,
                   VECS[i].b_drv, VECS[i].b_exp});
        end

        // R1: address boundaries
        b_store_a_read(8'h00, 8'h3C);
        b_store_a_read(8'hFF, 8'hE1);
        b_store_a_read(8'h80, 8'h96);

        // R11: reset in the middle of a read stops the drive
        @(negedge clk); set_a(S, 8'h41);
        @(negedge clk); set_a(RD, 8'h00);
        #5;
        check(a_bus_drv && a_bus_out == 8'h01, "R11 read before reset",
              {23'd0, a_bus_drv, a_bus_out}, {23'd0, 1'b1, 8'h01});
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        #5;
        check(!a_bus_drv && a_bus_out == 8'h00 && !a_clash, "R11 reset stops read",
              {22'd0, a_clash, a_bus_drv, a_bus_out}, 32'd0);
        set_a(I, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule